// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Stage with Metric Renormalization

This block performs the add-compare-select work of a soft-decision Viterbi decoder for a rate-1/2 convolutional code with 64 trellis states (constraint length 7). For each decoding step it accepts two 8-bit soft symbols, one per code output. It forms a 5-bit branch metric for each of the 32 butterflies and updates all 64 path metrics in one cycle. It then emits a 64-bit word of survivor decisions, which a traceback unit outside this block consumes.

Path metrics are 8-bit unsigned and kept in two banks that swap roles after every step. Once the ACS results are written, the block looks at the new metric of state 0 only. If that value is above a fixed threshold, it subtracts the smallest of the 64 new metrics from all of them. The code generators are described by two 32-bit tables that give, for each butterfly, the expected bit on each code output. An init strobe sets the starting state. Software can read any current path metric through a small read port.

Top module: `viterbi_acs_norm`

## Requirements
- R1: After reset, sym_ready is 1, dec_valid is 0 and dec_word is 0. The current metrics are 0 for state 0 and 63 for every other state.
- R2: A cycle with init_req high sets the current metric of state init_state to 0 and all other states to 63. On the following cycle dec_word is 0 and dec_valid is 0.
- R3: Butterfly j uses bits exp_a[j] and exp_b[j]. Each symbol is XORed with 0x00 when its bit is 0 and with 0xFF when it is 1, giving xa and xb. The branch metric is bm = ((xa + xb + 1) >> 1) >> 3, so 0..31. The opposite branch uses 31 - bm.
- R4: For butterfly j, with old metrics p = old[j] and q = old[j+32]: new[2j] = min(p + bm, q + 31 - bm) and new[2j+1] = min(p + 31 - bm, q + bm). Every addition saturates at 255.
- R5: Bit k of dec_word belongs to new state k. It is 1 when the candidate coming from the upper predecessor (j+32) equals the selected minimum, so a tie selects the upper predecessor.
- R6: When the new metric of state 0 exceeds 105, the minimum of all 64 new metrics is subtracted from every one of them before the step ends. Otherwise the metrics are left unchanged.
- R7: The metrics produced by a step are the inputs of the next step. Reading metric_rd_idx returns the current metric of that state.
- R8: A symbol pair is accepted on a clock edge where sym_valid and sym_ready are both high. sym_ready is then low for the next two cycles. dec_valid is high for exactly one cycle, which starts after the second edge following acceptance, and sym_ready is high again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Load starting metrics |
| init_state | input | 6 | Starting state used by init_req |
| exp_a | input | 32 | Expected bit of code output A for each butterfly |
| exp_b | input | 32 | Expected bit of code output B for each butterfly |
| sym_valid | input | 1 | Symbol pair present |
| sym_ready | output | 1 | Block can accept a symbol pair |
| sym_a | input | 8 | Soft symbol for code output A |
| sym_b | input | 8 | Soft symbol for code output B |
| dec_valid | output | 1 | One-cycle strobe marking a new decision word |
| dec_word | output | 64 | Survivor decisions, bit k for new state k |
| metric_rd_idx | input | 6 | State whose current metric is read |
| metric_rd_data | output | 8 | Current metric of the selected state |

## Verification
The assertions rely on a few input conventions. init_req is never raised while a step is in progress. The expected-bit tables are held constant between init and the last step. The reset pulse lasts at least one clock edge. The stimulus meets these by driving init only when the block is idle, by setting the tables once per run before init, and by holding reset for several cycles. Random symbol pairs run for hundreds of steps so that metrics climb past the threshold and trigger normalization. Directed pairs (all zeros, all ones, mixed) pin down the two extreme branch-metric values.

// File: rtl/acs_pkg.sv
// Shared constants and types for the add-compare-select stage.
// Assumes a rate-1/2 code and a 5-bit branch metric.
package acs_pkg;
    localparam int unsigned BM_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACS  = 2'd1,
        ST_FIN  = 2'd2
    } acs_state_e;
endpackage

// File: rtl/acs_bmu.sv
// Branch metric unit for one butterfly. The output is the rounded average of
// the two symbol distances, scaled down to BM_W bits.
// Assumes SYM_W > BM_W.
module acs_bmu #(
    parameter int unsigned SYM_W = 8,
    parameter int unsigned BM_W  = 5
) (
    input  logic [SYM_W-1:0] sym_a,
    input  logic [SYM_W-1:0] sym_b,
    input  logic             want_a,
    input  logic             want_b,
    output logic [BM_W-1:0]  bm
);
    localparam int unsigned SHIFT = SYM_W + 1 - BM_W;

    logic [SYM_W-1:0] dist_a;
    logic [SYM_W-1:0] dist_b;
    logic [SYM_W:0]   sum_r;

    // distance of each symbol from the expected hard value, averaged and scaled
    always_comb begin
        dist_a = sym_a ^ {SYM_W{want_a}};
        dist_b = sym_b ^ {SYM_W{want_b}};
        sum_r  = {1'b0, dist_a} + {1'b0, dist_b} + {{SYM_W{1'b0}}, 1'b1};
        bm     = BM_W'(sum_r >> SHIFT);
    end
endmodule

// File: rtl/acs_butterfly.sv
// One radix-2 butterfly. It takes two old metrics, produces two new metrics
// and the two decision bits. The opposite branch uses the complement metric.
// Assumes unsigned metrics; every addition saturates at the all-ones value.
module acs_butterfly #(
    parameter int unsigned MET_W = 8,
    parameter int unsigned BM_W  = 5
) (
    input  logic [MET_W-1:0] old_lo,
    input  logic [MET_W-1:0] old_hi,
    input  logic [BM_W-1:0]  bm,
    output logic [MET_W-1:0] new_even,
    output logic [MET_W-1:0] new_odd,
    output logic             dec_even,
    output logic             dec_odd
);
    function automatic logic [MET_W-1:0] sat_add(input logic [MET_W-1:0] m,
                                                 input logic [BM_W-1:0]  b);
        logic [MET_W:0] s;
        s = {1'b0, m} + (MET_W+1)'(b);
        return s[MET_W] ? {MET_W{1'b1}} : s[MET_W-1:0];
    endfunction

    logic [BM_W-1:0]  bm_c;
    logic [MET_W-1:0] ev_lo, ev_hi, od_lo, od_hi;

    // candidate sums, then select the smaller; a tie goes to the upper predecessor
    always_comb begin
        bm_c     = ~bm;
        ev_lo    = sat_add(old_lo, bm);
        ev_hi    = sat_add(old_hi, bm_c);
        od_lo    = sat_add(old_lo, bm_c);
        od_hi    = sat_add(old_hi, bm);
        dec_even = (ev_hi <= ev_lo);
        dec_odd  = (od_hi <= od_lo);
        new_even = dec_even ? ev_hi : ev_lo;
        new_odd  = dec_odd  ? od_hi : od_lo;
    end
endmodule

// File: rtl/acs_min_tree.sv
// Balanced minimum tree over N unsigned values.
// Assumes N is a power of two and at least 2.
module acs_min_tree #(
    parameter int unsigned N = 64,
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] vals [N],
    output logic [W-1:0] min_val
);
    localparam int unsigned NODES = 2 * N - 1;

    logic [W-1:0] node [NODES];

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_leaf
            assign node[N - 1 + i] = vals[i];
        end
        for (i = 0; i < N - 1; i++) begin : g_inner
            assign node[i] = (node[2*i+2] < node[2*i+1]) ? node[2*i+2] : node[2*i+1];
        end
    endgenerate

    assign min_val = node[0];
endmodule

// File: rtl/viterbi_acs_norm.sv
// Add-compare-select stage for a 64-state rate-1/2 Viterbi decoder.
// One step takes three cycles: capture the symbols, run ACS into the spare
// bank, then renormalize if needed and swap the banks.
// Assumes init_req is raised only while idle and exp_a/exp_b stay constant
// during decoding.
module viterbi_acs_norm #(
    parameter int unsigned NSTATES     = 64,
    parameter int unsigned SYM_W       = 8,
    parameter int unsigned MET_W       = 8,
    parameter int unsigned NORM_THRESH = 105,
    parameter int unsigned INIT_BIAS   = 63,
    localparam int unsigned NBFLY      = NSTATES / 2,
    localparam int unsigned IDX_W      = $clog2(NSTATES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_req,
    input  logic [IDX_W-1:0]   init_state,
    input  logic [NBFLY-1:0]   exp_a,
    input  logic [NBFLY-1:0]   exp_b,
    input  logic               sym_valid,
    output logic               sym_ready,
    input  logic [SYM_W-1:0]   sym_a,
    input  logic [SYM_W-1:0]   sym_b,
    output logic               dec_valid,
    output logic [NSTATES-1:0] dec_word,
    input  logic [IDX_W-1:0]   metric_rd_idx,
    output logic [MET_W-1:0]   metric_rd_data
);
    import acs_pkg::*;

    acs_state_e       state;
    logic             sel;
    logic             norm_flag;
    logic [SYM_W-1:0] sa_q, sb_q;
    logic [MET_W-1:0] bank0 [NSTATES];
    logic [MET_W-1:0] bank1 [NSTATES];
    logic [MET_W-1:0] old_m [NSTATES];
    logic [MET_W-1:0] spare_m [NSTATES];
    logic [MET_W-1:0] acs_m [NSTATES];
    logic [NSTATES-1:0] dec_bits;
    logic [MET_W-1:0] spare_min;
    logic             norm_fire;
    logic             any_zero_rd;

    // steer the read (old) and write (spare) banks by the ping-pong select
    always_comb begin
        for (int i = 0; i < NSTATES; i++) begin
            old_m[i]   = sel ? bank1[i] : bank0[i];
            spare_m[i] = sel ? bank0[i] : bank1[i];
        end
    end

    genvar j;
    generate
        for (j = 0; j < NBFLY; j++) begin : g_bfly
            logic [BM_W-1:0] bm_j;
            acs_bmu #(.SYM_W(SYM_W), .BM_W(BM_W)) u_bmu (
                .sym_a (sa_q),
                .sym_b (sb_q),
                .want_a(exp_a[j]),
                .want_b(exp_b[j]),
                .bm    (bm_j)
            );
            acs_butterfly #(.MET_W(MET_W), .BM_W(BM_W)) u_bf (
                .old_lo  (old_m[j]),
                .old_hi  (old_m[j + NBFLY]),
                .bm      (bm_j),
                .new_even(acs_m[2*j]),
                .new_odd (acs_m[2*j+1]),
                .dec_even(dec_bits[2*j]),
                .dec_odd (dec_bits[2*j+1])
            );
        end
    endgenerate

    acs_min_tree #(.N(NSTATES), .W(MET_W)) u_min (
        .vals   (spare_m),
        .min_val(spare_min)
    );

    // renormalization trigger: only state 0 of the fresh metrics is inspected
    assign norm_fire = (state == ST_FIN) && (spare_m[0] > MET_W'(NORM_THRESH));

    // main sequencer, bank writes and decision register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sel       <= 1'b0;
            norm_flag <= 1'b0;
            sa_q      <= '0;
            sb_q      <= '0;
            dec_valid <= 1'b0;
            dec_word  <= '0;
            for (int i = 0; i < NSTATES; i++) begin
                bank0[i] <= (i == 0) ? '0 : MET_W'(INIT_BIAS);
                bank1[i] <= '0;
            end
        end else begin
            dec_valid <= 1'b0;
            if (init_req) begin
                state    <= ST_IDLE;
                dec_word <= '0;
                for (int i = 0; i < NSTATES; i++) begin
                    if (sel) bank1[i] <= (IDX_W'(i) == init_state) ? '0 : MET_W'(INIT_BIAS);
                    else     bank0[i] <= (IDX_W'(i) == init_state) ? '0 : MET_W'(INIT_BIAS);
                end
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (sym_valid) begin
                            sa_q  <= sym_a;
                            sb_q  <= sym_b;
                            state <= ST_ACS;
                        end
                    end
                    ST_ACS: begin
                        dec_word <= dec_bits;
                        for (int i = 0; i < NSTATES; i++) begin
                            if (sel) bank0[i] <= acs_m[i];
                            else     bank1[i] <= acs_m[i];
                        end
                        state <= ST_FIN;
                    end
                    ST_FIN: begin
                        if (norm_fire) begin
                            for (int i = 0; i < NSTATES; i++) begin
                                if (sel) bank0[i] <= spare_m[i] - spare_min;
                                else     bank1[i] <= spare_m[i] - spare_min;
                            end
                        end
                        norm_flag <= norm_fire;
                        sel       <= ~sel;
                        dec_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign sym_ready      = (state == ST_IDLE);
    assign metric_rd_data = old_m[metric_rd_idx];

    // observation only: does any current metric sit at zero
    always_comb begin
        any_zero_rd = 1'b0;
        for (int i = 0; i < NSTATES; i++) any_zero_rd = any_zero_rd | (old_m[i] == '0);
    end

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready && !init_req) |=> !sym_ready);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    a_r8_ready_with_dec: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> sym_ready);

    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (dec_word == '0 && !dec_valid));

    a_r6_norm_hits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && norm_flag) |-> any_zero_rd);
endmodule

// File: tb/sim_viterbi_acs_norm.sv
module sim_viterbi_acs_norm;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0;
    logic [5:0]  init_state = '0;
    logic [31:0] exp_a = '0, exp_b = '0;
    logic        sym_valid = 1'b0;
    logic        sym_ready;
    logic [7:0]  sym_a = '0, sym_b = '0;
    logic        dec_valid;
    logic [63:0] dec_word;
    logic [5:0]  metric_rd_idx = '0;
    logic [7:0]  metric_rd_data;

    int checks = 0, errors = 0, norm_count = 0, cycles = 0;
    int mdl [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    viterbi_acs_norm u0 (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_state(init_state),
        .exp_a(exp_a), .exp_b(exp_b), .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_a(sym_a), .sym_b(sym_b), .dec_valid(dec_valid), .dec_word(dec_word),
        .metric_rd_idx(metric_rd_idx), .metric_rd_data(metric_rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int bm_of(input int sa, input int sb, input bit ea, input bit eb);
        int xa, xb;
        xa = ea ? (sa ^ 255) : sa;
        xb = eb ? (sb ^ 255) : sb;
        return (((xa + xb + 1) >> 1) >> 3) & 31;
    endfunction

    function automatic int sadd(input int a, input int b);
        return (a + b > 255) ? 255 : a + b;
    endfunction

    task automatic model_step(input int sa, input int sb, output logic [63:0] dexp,
                              output bit normed);
        int nm [64];
        int bm, lo, hi, mn;
        for (int j = 0; j < 32; j++) begin
            bm = bm_of(sa, sb, exp_a[j], exp_b[j]);
            lo = sadd(mdl[j], bm);      hi = sadd(mdl[j+32], 31 - bm);
            dexp[2*j] = (hi <= lo);     nm[2*j] = (hi <= lo) ? hi : lo;
            lo = sadd(mdl[j], 31 - bm); hi = sadd(mdl[j+32], bm);
            dexp[2*j+1] = (hi <= lo);   nm[2*j+1] = (hi <= lo) ? hi : lo;
        end
        normed = (nm[0] > 105);
        mn = 255;
        for (int i = 0; i < 64; i++) if (nm[i] < mn) mn = nm[i];
        for (int i = 0; i < 64; i++) mdl[i] = normed ? nm[i] - mn : nm[i];
    endtask

    task automatic check_metrics(input string req);
        int bad = 0;
        for (int i = 0; i < 64; i++) begin
            metric_rd_idx = 6'(i);
            #1;
            if (metric_rd_data != 8'(mdl[i]) && bad == 0) begin
                bad = 1;
                chk(1'b0, req, $sformatf("metric[%0d]", i), metric_rd_data, mdl[i]);
            end
        end
        if (bad == 0) chk(1'b1, req, "metrics", 0, 0);
    endtask

    task automatic do_init(input int st);
        @(negedge clk);
        init_req = 1'b1; init_state = 6'(st);
        @(negedge clk);
        init_req = 1'b0;
        chk(dec_word == '0, "R2", "dec_word after init", dec_word, 0);
        chk(dec_valid == 1'b0, "R2", "dec_valid after init", dec_valid, 0);
        for (int i = 0; i < 64; i++) mdl[i] = (i == st) ? 0 : 63;
        check_metrics("R2");
    endtask

    task automatic do_step(input int sa, input int sb, input string req);
        logic [63:0] dexp;
        bit normed;
        @(negedge clk);
        sym_valid = 1'b1; sym_a = 8'(sa); sym_b = 8'(sb);
        @(negedge clk);
        sym_valid = 1'b0;
        chk(sym_ready == 1'b0, "R8", "ready after accept", sym_ready, 0);
        model_step(sa, sb, dexp, normed);
        if (normed) norm_count++;
        @(negedge clk);
        chk(sym_ready == 1'b0 && dec_valid == 1'b0, "R8", "busy second cycle",
            {sym_ready, dec_valid}, 0);
        @(negedge clk);
        chk(dec_valid == 1'b1 && sym_ready == 1'b1, "R8", "dec_valid and ready",
            {dec_valid, sym_ready}, 3);
        chk(dec_word == dexp, "R5", {req, " decisions"}, dec_word, dexp);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R8", "single pulse", dec_valid, 0);
        check_metrics(normed ? "R6" : req);
    endtask

    // watchdog: an expired run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        exp_a = $urandom; exp_b = $urandom;
        repeat (4) @(negedge clk);
        chk(sym_ready == 1'b1, "R1", "ready in reset", sym_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sym_ready == 1'b1 && dec_valid == 1'b0, "R1", "ready/valid after reset",
            {sym_ready, dec_valid}, 2);
        chk(dec_word == '0, "R1", "dec_word after reset", dec_word, 0);
        for (int i = 0; i < 64; i++) mdl[i] = (i == 0) ? 0 : 63;
        check_metrics("R1");

        // directed corners: zero distance, full distance, mixed
        do_step(0, 0, "R3");
        do_step(255, 255, "R3");
        do_step(255, 0, "R4");
        do_step(128, 127, "R4");

        do_init(37);
        do_step(0, 255, "R7");
        do_step(17, 200, "R7");

        // long random run to drive metrics over the threshold
        for (int n = 0; n < 400; n++) begin
            do_step(int'($urandom_range(255)), int'($urandom_range(255)), "R4");
        end
        chk(norm_count > 0, "R6", "normalization count", norm_count, 1);

        do_init(63);
        for (int n = 0; n < 40; n++) begin
            do_step(int'($urandom_range(1) * 255), int'($urandom_range(1) * 255), "R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule